// File: doc/BRIEF.md
# Linked-List Directory Sharer Manager

This block holds, for each memory line of a directory, the set of nodes that cache that line. Each line owns a header that keeps the first sharer inline, together with a link into a shared pool of entries. Every pool entry carries a sharer node number, a link to the next entry and an end-of-list flag. Unused pool entries sit on a free list threaded through the same link field. A line that has a single sharer therefore costs no pool entry at all.

A controller issues one command at a time. The add command records a sharer after a read miss. The remove command drops a sharer after a replacement hint. The invalidate command walks a line's list and reports each sharer on a one-cycle pulse. Every reported sharer is unlinked at once and its entry goes back to the free list. An invalidate command carries a budget. When the budget runs out before the list does, the command stops with a partial status and leaves only the sharers that have not been reported. A later invalidate command on the same line picks up from that point.

The FSM has five states, each named here with its transitions. S_IDLE accepts a command and moves to S_ADD_SCAN, S_DROP_SCAN or S_INV_POP, or straight to S_FINISH for the reserved code. S_ADD_SCAN and S_DROP_SCAN check the header in their first cycle and then visit one pool entry per cycle. When a decision is reached they move to S_FINISH. S_INV_POP removes one sharer per cycle and moves to S_FINISH when the list is empty or the budget is used up. S_FINISH raises done for one cycle and returns to S_IDLE.

Top module: `sharer_dir`

## Requirements
- R1: After reset, busy, done and sharer_valid are low, every line is empty, and all pool entries are free.
- R2: Adding a node to an empty line returns status 0 (ok) and stores that node in the header, using no pool entry.
- R3: Adding a new node to a line that already has a sharer takes one entry from the free list and returns status 0.
- R4: Adding a node that is already a sharer of the line returns status 1 (unchanged) and alters nothing.
- R5: Adding a new node to a non-empty line while the free list is empty returns status 2 (full) and alters nothing.
- R6: Removing a present sharer returns status 0 and gives back a pool entry when the line held more than one sharer.
- R7: Removing a node that is not a sharer of the line returns status 1 and alters nothing.
- R8: Invalidate (op 2) with a budget at least the sharer count reports every sharer exactly once, leaves the line empty, frees its entries and returns status 0.
- R9: Invalidate with a budget below the sharer count reports exactly budget distinct sharers and removes them. It returns status 3 (partial), and the unreported sharers remain for a later invalidate.
- R10: A command is taken only while busy is low. Busy stays high from the next cycle through the done cycle. Done is a one-cycle pulse, and every sharer pulse comes before it.
- R11: Op codes are 0 add, 1 remove, 2 invalidate and 3 reserved. The reserved code completes with status 1 and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, taken while busy is low |
| cmd_op | input | 2 | Operation code (R11) |
| cmd_line | input | LINE_W | Line index |
| cmd_node | input | NODE_W | Node for add or remove |
| cmd_budget | input | BUDGET_W | Maximum sharers to report on invalidate |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | Result code, valid with done |
| sharer_valid | output | 1 | One-cycle pulse per reported sharer |
| sharer_node | output | NODE_W | Reported sharer node |

## Verification
A corrupted link or free-list pointer does not show up at once. It appears later as a wrong status, for example full being reported while entries are still free, or ok being reported where the line is really full. It can also appear as a sharer that is reported twice, lost, or reported on the wrong line. All of these become visible only when that line is next invalidated. For this reason the stimulus drains lines often with invalidate commands and compares each reported set against a per-line reference set. Any fault is therefore exposed within a few commands of its cause, not at the end of the run.

// File: rtl/sharer_dir_pkg.sv
package sharer_dir_pkg;
    typedef enum logic [1:0] {OP_ADD, OP_DROP, OP_INVAL, OP_RSVD} dir_op_e;
    typedef enum logic [1:0] {RES_OK, RES_NOCHG, RES_FULL, RES_PARTIAL} dir_res_e;
    typedef enum logic [2:0] {S_IDLE, S_ADD_SCAN, S_DROP_SCAN, S_INV_POP, S_FINISH} dir_state_e;
endpackage

// File: rtl/sharer_hdr_table.sv
module sharer_hdr_table #(
    parameter int LINES  = 16,
    parameter int NODE_W = 4,
    parameter int IDX_W  = 3,
    localparam int LINE_W = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINE_W-1:0] rd_line,
    output logic              rd_first_v,
    output logic [NODE_W-1:0] rd_first,
    output logic              rd_link_v,
    output logic [IDX_W-1:0]  rd_link,
    input  logic              wr_en,
    input  logic [LINE_W-1:0] wr_line,
    input  logic              wr_first_v,
    input  logic [NODE_W-1:0] wr_first,
    input  logic              wr_link_v,
    input  logic [IDX_W-1:0]  wr_link
);
    logic              first_v [LINES];
    logic [NODE_W-1:0] first   [LINES];
    logic              link_v  [LINES];
    logic [IDX_W-1:0]  link    [LINES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LINES; i++) begin
                first_v[i] <= 1'b0;
                first[i]   <= '0;
                link_v[i]  <= 1'b0;
                link[i]    <= '0;
            end
        end else if (wr_en) begin
            first_v[wr_line] <= wr_first_v;
            first[wr_line]   <= wr_first;
            link_v[wr_line]  <= wr_link_v;
            link[wr_line]    <= wr_link;
        end
    end

    assign rd_first_v = first_v[rd_line];
    assign rd_first   = first[rd_line];
    assign rd_link_v  = link_v[rd_line];
    assign rd_link    = link[rd_line];
endmodule

// File: rtl/sharer_link_store.sv
module sharer_link_store #(
    parameter int DEPTH  = 8,
    parameter int NODE_W = 4,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [NODE_W-1:0] rd_node,
    output logic [IDX_W-1:0]  rd_next,
    output logic              rd_end,
    input  logic              put_en,
    input  logic [IDX_W-1:0]  put_idx,
    input  logic [NODE_W-1:0] put_node,
    input  logic [IDX_W-1:0]  put_next,
    input  logic              put_end,
    input  logic              relink_en,
    input  logic [IDX_W-1:0]  relink_idx,
    input  logic [IDX_W-1:0]  relink_next,
    input  logic              relink_end,
    input  logic              take_en,
    input  logic              give_en,
    input  logic [IDX_W-1:0]  give_idx,
    output logic [IDX_W-1:0]  free_head,
    output logic              free_empty,
    output logic [CNT_W-1:0]  free_count
);
    logic [NODE_W-1:0] e_node [DEPTH];
    logic [IDX_W-1:0]  e_next [DEPTH];
    logic              e_end  [DEPTH];
    logic [IDX_W-1:0]  head_q;
    logic [CNT_W-1:0]  cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                e_node[i] <= '0;
                e_next[i] <= IDX_W'(i + 1);
                e_end[i]  <= 1'b0;
            end
            head_q <= '0;
            cnt_q  <= CNT_W'(DEPTH);
        end else begin
            if (put_en) begin
                e_node[put_idx] <= put_node;
                e_next[put_idx] <= put_next;
                e_end[put_idx]  <= put_end;
            end
            if (relink_en) begin
                e_next[relink_idx] <= relink_next;
                e_end[relink_idx]  <= relink_end;
            end
            if (give_en) begin
                e_next[give_idx] <= head_q;
                head_q <= give_idx;
                cnt_q  <= cnt_q + 1'b1;
            end else if (take_en) begin
                head_q <= e_next[head_q];
                cnt_q  <= cnt_q - 1'b1;
            end
        end
    end

    assign rd_node    = e_node[rd_idx];
    assign rd_next    = e_next[rd_idx];
    assign rd_end     = e_end[rd_idx];
    assign free_head  = head_q;
    assign free_empty = (cnt_q == '0);
    assign free_count = cnt_q;
endmodule

// File: rtl/sharer_dir.sv
module sharer_dir
    import sharer_dir_pkg::*;
#(
    parameter int LINES    = 16,
    parameter int NODE_W   = 4,
    parameter int DEPTH    = 8,
    parameter int BUDGET_W = 4,
    localparam int LINE_W  = (LINES > 1) ? $clog2(LINES) : 1,
    localparam int IDX_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W   = $clog2(DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_valid,
    input  logic [1:0]          cmd_op,
    input  logic [LINE_W-1:0]   cmd_line,
    input  logic [NODE_W-1:0]   cmd_node,
    input  logic [BUDGET_W-1:0] cmd_budget,
    output logic                busy,
    output logic                done,
    output logic [1:0]          status,
    output logic                sharer_valid,
    output logic [NODE_W-1:0]   sharer_node
);
    dir_state_e state_q, state_n;
    dir_res_e   res_q, res_n;

    logic [LINE_W-1:0]   line_q;
    logic [NODE_W-1:0]   node_q;
    logic [BUDGET_W-1:0] budget_q, popped_q;
    logic                at_hdr_q, cur_v_q, prev_hdr_q;
    logic [IDX_W-1:0]    cur_q, prev_q;
    logic                sh_v_q;
    logic [NODE_W-1:0]   sh_node_q;

    logic              h_fv, h_lv;
    logic [NODE_W-1:0] h_first;
    logic [IDX_W-1:0]  h_link;
    logic              hw_en, hw_fv, hw_lv;
    logic [NODE_W-1:0] hw_first;
    logic [IDX_W-1:0]  hw_link;

    logic [IDX_W-1:0]  rd_idx, s_next, free_head, put_idx, put_next, relink_idx, relink_next, give_idx;
    logic [NODE_W-1:0] s_node, put_node;
    logic              s_end, put_en, put_end, relink_en, relink_end, take_en, give_en;
    logic              free_empty;
    logic [CNT_W-1:0]  free_count;

    logic accept, advance, leave_hdr, emit;

    sharer_hdr_table #(.LINES(LINES), .NODE_W(NODE_W), .IDX_W(IDX_W)) u_hdr (
        .clk(clk), .rst_n(rst_n), .rd_line(line_q),
        .rd_first_v(h_fv), .rd_first(h_first), .rd_link_v(h_lv), .rd_link(h_link),
        .wr_en(hw_en), .wr_line(line_q), .wr_first_v(hw_fv), .wr_first(hw_first),
        .wr_link_v(hw_lv), .wr_link(hw_link)
    );

    sharer_link_store #(.DEPTH(DEPTH), .NODE_W(NODE_W)) u_store (
        .clk(clk), .rst_n(rst_n), .rd_idx(rd_idx),
        .rd_node(s_node), .rd_next(s_next), .rd_end(s_end),
        .put_en(put_en), .put_idx(put_idx), .put_node(put_node), .put_next(put_next), .put_end(put_end),
        .relink_en(relink_en), .relink_idx(relink_idx), .relink_next(relink_next), .relink_end(relink_end),
        .take_en(take_en), .give_en(give_en), .give_idx(give_idx),
        .free_head(free_head), .free_empty(free_empty), .free_count(free_count)
    );

    // the header's first pool entry is read while on the header or popping
    assign rd_idx = (at_hdr_q || state_q == S_INV_POP) ? h_link : cur_q;

    always_comb begin
        state_n = state_q;   res_n = res_q;
        accept = 1'b0;  advance = 1'b0;  leave_hdr = 1'b0;  emit = 1'b0;
        hw_en = 1'b0;  hw_fv = h_fv;  hw_first = h_first;  hw_lv = h_lv;  hw_link = h_link;
        put_en = 1'b0;  put_idx = free_head;  put_node = node_q;  put_next = h_link;  put_end = !h_lv;
        relink_en = 1'b0;  relink_idx = prev_q;  relink_next = s_next;  relink_end = s_end;
        take_en = 1'b0;  give_en = 1'b0;  give_idx = h_link;
        unique case (state_q)
            S_IDLE: begin
                if (cmd_valid) begin
                    accept = 1'b1;
                    unique case (dir_op_e'(cmd_op))
                        OP_ADD:   state_n = S_ADD_SCAN;
                        OP_DROP:  state_n = S_DROP_SCAN;
                        OP_INVAL: state_n = S_INV_POP;
                        OP_RSVD:  begin state_n = S_FINISH; res_n = RES_NOCHG; end
                    endcase
                end
            end
            S_ADD_SCAN: begin
                if (at_hdr_q) begin
                    if (!h_fv) begin
                        hw_en = 1'b1;  hw_fv = 1'b1;  hw_first = node_q;
                        res_n = RES_OK;  state_n = S_FINISH;
                    end else if (h_first == node_q) begin
                        res_n = RES_NOCHG;  state_n = S_FINISH;
                    end else leave_hdr = 1'b1;
                end else if (cur_v_q) begin
                    if (s_node == node_q) begin
                        res_n = RES_NOCHG;  state_n = S_FINISH;
                    end else advance = 1'b1;
                end else if (free_empty) begin
                    res_n = RES_FULL;  state_n = S_FINISH;
                end else begin
                    put_en = 1'b1;  take_en = 1'b1;
                    hw_en = 1'b1;  hw_lv = 1'b1;  hw_link = free_head;
                    res_n = RES_OK;  state_n = S_FINISH;
                end
            end
            S_DROP_SCAN: begin
                if (at_hdr_q) begin
                    if (!h_fv) begin
                        res_n = RES_NOCHG;  state_n = S_FINISH;
                    end else if (h_first == node_q) begin
                        hw_en = 1'b1;
                        if (h_lv) begin
                            hw_first = s_node;  hw_lv = !s_end;  hw_link = s_next;  give_en = 1'b1;
                        end else hw_fv = 1'b0;
                        res_n = RES_OK;  state_n = S_FINISH;
                    end else leave_hdr = 1'b1;
                end else if (cur_v_q) begin
                    if (s_node == node_q) begin
                        if (prev_hdr_q) begin
                            hw_en = 1'b1;  hw_lv = !s_end;  hw_link = s_next;
                        end else relink_en = 1'b1;
                        give_en = 1'b1;  give_idx = cur_q;
                        res_n = RES_OK;  state_n = S_FINISH;
                    end else advance = 1'b1;
                end else begin
                    res_n = RES_NOCHG;  state_n = S_FINISH;
                end
            end
            S_INV_POP: begin
                if (!h_fv) begin
                    res_n = RES_OK;  state_n = S_FINISH;
                end else if (popped_q == budget_q) begin
                    res_n = RES_PARTIAL;  state_n = S_FINISH;
                end else begin
                    emit = 1'b1;  hw_en = 1'b1;
                    if (h_lv) begin
                        hw_first = s_node;  hw_lv = !s_end;  hw_link = s_next;  give_en = 1'b1;
                    end else hw_fv = 1'b0;
                end
            end
            S_FINISH: state_n = S_IDLE;
            default:  state_n = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;   res_q <= RES_OK;
            line_q <= '0;  node_q <= '0;  budget_q <= '0;  popped_q <= '0;
            at_hdr_q <= 1'b0;  cur_v_q <= 1'b0;  prev_hdr_q <= 1'b1;
            cur_q <= '0;  prev_q <= '0;  sh_v_q <= 1'b0;  sh_node_q <= '0;
        end else begin
            state_q <= state_n;  res_q <= res_n;  sh_v_q <= emit;
            if (accept) begin
                line_q <= cmd_line;  node_q <= cmd_node;  budget_q <= cmd_budget;
                popped_q <= '0;  at_hdr_q <= 1'b1;  prev_hdr_q <= 1'b1;
            end
            if (state_n == S_FINISH) at_hdr_q <= 1'b0;
            if (leave_hdr) begin
                at_hdr_q <= 1'b0;  cur_q <= h_link;  cur_v_q <= h_lv;  prev_hdr_q <= 1'b1;
            end
            if (advance) begin
                prev_q <= cur_q;  prev_hdr_q <= 1'b0;  cur_q <= s_next;  cur_v_q <= !s_end;
            end
            if (emit) begin
                popped_q <= popped_q + 1'b1;  sh_node_q <= h_first;
            end
        end
    end

    always_comb begin
        busy         = (state_q != S_IDLE);
        done         = (state_q == S_FINISH);
        status       = done ? res_q : RES_OK;
        sharer_valid = sh_v_q;
        sharer_node  = sh_node_q;
    end
endmodule

// File: rtl/sharer_dir_chk.sv
module sharer_dir_chk #(
    parameter int DEPTH    = 8,
    parameter int BUDGET_W = 4,
    localparam int CNT_W   = $clog2(DEPTH + 1)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cmd_valid,
    input logic [BUDGET_W-1:0] cmd_budget,
    input logic                busy,
    input logic                done,
    input logic [1:0]          status,
    input logic                sharer_valid,
    input logic                free_empty,
    input logic [CNT_W-1:0]    free_count
);
    logic [BUDGET_W-1:0] bud_q, seen_q;
    logic [CNT_W-1:0]    cnt_at_cmd_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bud_q <= '0;  seen_q <= '0;  cnt_at_cmd_q <= CNT_W'(DEPTH);
        end else if (cmd_valid && !busy) begin
            bud_q <= cmd_budget;  seen_q <= '0;  cnt_at_cmd_q <= free_count;
        end else if (sharer_valid) begin
            seen_q <= seen_q + 1'b1;
        end
    end

    p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
    p_idle_after_done_r10: assert property (@(posedge clk) disable iff (!rst_n) done |=> !busy);
    p_busy_from_cmd_r10: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(cmd_valid));
    p_sharer_before_done_r8: assert property (@(posedge clk) disable iff (!rst_n) sharer_valid |-> busy && !done);
    p_budget_bound_r9: assert property (@(posedge clk) disable iff (!rst_n) sharer_valid |-> seen_q < bud_q);
    p_full_when_empty_r5: assert property (@(posedge clk) disable iff (!rst_n) (done && status == 2'd2) |-> free_empty);
    p_unchanged_pool_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (status == 2'd1 || status == 2'd2)) |-> free_count == cnt_at_cmd_q);
    p_pool_bound_r6: assert property (@(posedge clk) disable iff (!rst_n) free_count <= CNT_W'(DEPTH));
endmodule

bind sharer_dir sharer_dir_chk #(.DEPTH(DEPTH), .BUDGET_W(BUDGET_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_budget(cmd_budget),
    .busy(busy), .done(done), .status(status), .sharer_valid(sharer_valid),
    .free_empty(free_empty), .free_count(free_count)
);

// File: tb/sharer_dir_bench.sv
`timescale 1ns/1ps
module sharer_dir_bench;
    localparam int LINES = 16, NODE_W = 4, DEPTH = 8, BUDGET_W = 4;
    localparam int NODES = 1 << NODE_W;

    logic clk = 1'b0, rst_n = 1'b0, cmd_valid = 1'b0;
    logic [1:0] cmd_op = '0;
    logic [3:0] cmd_line = '0;
    logic [NODE_W-1:0] cmd_node = '0;
    logic [BUDGET_W-1:0] cmd_budget = '0;
    logic busy, done, sharer_valid;
    logic [1:0] status;
    logic [NODE_W-1:0] sharer_node;

    int n_run = 0, n_fail = 0;
    logic [NODES-1:0] model [LINES];

    always #2 clk = ~clk;

    sharer_dir #(.LINES(LINES), .NODE_W(NODE_W), .DEPTH(DEPTH), .BUDGET_W(BUDGET_W)) u_sharer_dir (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_line(cmd_line),
        .cmd_node(cmd_node), .cmd_budget(cmd_budget), .busy(busy), .done(done), .status(status),
        .sharer_valid(sharer_valid), .sharer_node(sharer_node)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int used_entries();
        int u = 0;
        for (int l = 0; l < LINES; l++) if ($countones(model[l]) > 1) u += $countones(model[l]) - 1;
        return u;
    endfunction

    task automatic exec(input int op, input int line, input int node, input int bud);
        logic [NODES-1:0] got = '0;
        int n = 0, guard = 0, exp_st = 0, cnt = 0;
        bit dupe = 0;
        string tag;
        logic [1:0] st = '0;
        // expected result from the reference sets
        case (op)
            0: begin
                if (model[line] == '0) begin exp_st = 0; tag = "R2"; end
                else if (model[line][node]) begin exp_st = 1; tag = "R4"; end
                else if (used_entries() == DEPTH) begin exp_st = 2; tag = "R5"; end
                else begin exp_st = 0; tag = "R3"; end
            end
            1: begin
                if (model[line][node]) begin exp_st = 0; tag = "R6"; end
                else begin exp_st = 1; tag = "R7"; end
            end
            2: begin
                cnt = $countones(model[line]);
                if (cnt <= bud) begin exp_st = 0; tag = "R8"; end
                else begin exp_st = 3; tag = "R9"; end
            end
            default: begin exp_st = 1; tag = "R11"; end
        endcase
        @(negedge clk);
        cmd_valid = 1'b1;  cmd_op = 2'(op);  cmd_line = 4'(line);
        cmd_node = NODE_W'(node);  cmd_budget = BUDGET_W'(bud);
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(busy === 1'b1, "R10 busy after accept", busy, 1);
        while (guard < 200) begin
            if (sharer_valid) begin
                if (got[sharer_node]) dupe = 1;
                got[sharer_node] = 1'b1;
                n++;
            end
            if (done) begin st = status; break; end
            guard++;
            @(negedge clk);
        end
        chk(guard < 200 && st == 2'(exp_st), tag, st, exp_st);
        if (op == 2) begin
            chk(!dupe, {tag, " no repeat"}, dupe, 0);
            if (exp_st == 0) begin
                chk(got == model[line], {tag, " sharer set"}, got, model[line]);
            end else begin
                chk(n == bud && (got & ~model[line]) == '0, {tag, " partial subset"}, n, bud);
            end
            model[line] = model[line] & ~got;
        end else if (op == 0 && exp_st == 0) begin
            model[line][node] = 1'b1;
        end else if (op == 1 && exp_st == 0) begin
            model[line][node] = 1'b0;
        end
        if (op != 2) chk(n == 0, {tag, " no sharer pulse"}, n, 0);
        @(negedge clk);
        chk(!done && !busy, "R10 done single pulse", {done, busy}, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd5151));
        for (int l = 0; l < LINES; l++) model[l] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !sharer_valid, "R1 reset outputs", {busy, done, sharer_valid}, 0);
        exec(2, 3, 0, 15);                       // R1 empty line drains nothing
        exec(0, 0, 5, 0);                        // R2 inline first sharer
        exec(0, 0, 5, 0);                        // R4 duplicate
        for (int l = 1; l < 8; l++) exec(0, l, 1, 0);   // R2 no pool use
        for (int k = 6; k < 14; k++) exec(0, 0, k, 0);  // R3 fill the pool
        exec(0, 0, 14, 0);                       // R5 full
        exec(0, 1, 2, 0);                        // R5 full on another line
        exec(0, 8, 3, 0);                        // R2 still fine when pool empty
        exec(1, 0, 9, 0);                        // R6 remove from middle
        exec(1, 0, 9, 0);                        // R7 absent
        exec(0, 1, 14, 0);                       // R6 returned entry reused
        exec(1, 0, 5, 0);                        // R6 header sharer removed
        exec(3, 0, 0, 0);                        // R11 reserved code
        exec(2, 0, 0, 3);                        // R9 partial
        exec(2, 0, 0, 0);                        // R9 zero budget
        exec(2, 0, 0, 15);                       // R8 resume to empty
        exec(2, 0, 0, 15);                       // R8 already empty
        for (int i = 0; i < 600; i++) begin
            int r = $urandom_range(0, 9);
            int op = (r < 5) ? 0 : (r < 8) ? 1 : (r < 9) ? 2 : 3;
            int bud = ($urandom_range(0, 3) == 0) ? $urandom_range(0, 4) : 15;
            exec(op, $urandom_range(0, 3), $urandom_range(0, NODES - 1), bud);
        end
        for (int l = 0; l < LINES; l++) exec(2, l, 0, 15);  // R8 final drain
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule